// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block raises an open-drain, active-low alert towards the bus host whenever one of its enabled status bits is set. It then waits for the host to read from the shared alert response address. If its alert is pending when that read arrives, it sends back its own 7-bit device address one bit at a time and arbitrates on the shared data line. Any other responder that is alerting may be sending at the same time, so the lowest address wins.

The block sits beside a byte-level SMBus slave. That slave decodes the address phase and supplies a pulse at the start of each bit period (`bitSlot`, SCL low) and a pulse at each sample point (`bitSample`, SCL high). Both outputs are output enables: a 1 means "pull the wire low". A responder that loses arbitration keeps its alert asserted and answers a later poll. After a winning response, the alert stays asserted until two things have happened: the status has been read, and no enabled status bit is still set.

Top module: `alert_resp_top`

## Requirements
- R1: `alertDriveLow` rises one clock after any bit of `statusBits & statusMask` is 1. Status bits whose mask bit is 0 never assert it.
- R2: A response starts only on an `addrValid` pulse carrying `addrByte` = 7'b0001100 with `addrRead` = 1. A write to that address, or a read of any other address, leaves `sdaDriveLow` at 0.
- R3: During a response, each `bitSlot` presents the next address bit, MSB first. A 0 bit sets `sdaDriveLow` to 1 and a 1 bit sets it to 0, one clock after the pulse.
- R4: If a released 1 bit is sampled as 0 on `sdaIn` at `bitSample`, the block sets `arbLost`. It drives no further bits and keeps `alertDriveLow` asserted.
- R5: Once all 7 bits have been sampled without a loss, `respWon` goes to 1. `sdaDriveLow` returns to 0 on the next `bitSlot`.
- R6: While `alertDriveLow` is 0, a read of the alert response address is ignored and `sdaDriveLow` stays 0.
- R7: `alertDriveLow` deasserts only after three conditions hold: a won response, a `statusRead` pulse seen after that win, and no enabled status bit set. A read made before the win does not count. A read made while the fault persists takes effect when the fault clears.
- R8: A `busStop` pulse aborts a response in progress and releases `sdaDriveLow`. `respWon` stays 0.
- R9: `devAddr` must never equal the alert response address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devAddr | input | 7 | This device's own bus address |
| statusBits | input | NSTAT | Live fault status bits |
| statusMask | input | NSTAT | Per-bit alert enable |
| statusRead | input | 1 | Pulse: host has read the status registers |
| addrValid | input | 1 | Pulse: decoded address phase is valid |
| addrByte | input | 7 | Decoded 7-bit target address |
| addrRead | input | 1 | Direction of the decoded transaction, 1 = read |
| busStop | input | 1 | Pulse: STOP condition or bus abort |
| bitSlot | input | 1 | Pulse: start of a data bit period (SCL low) |
| bitSample | input | 1 | Pulse: data line sample point (SCL high) |
| sdaIn | input | 1 | Sampled level of the shared data line |
| alertDriveLow | output | 1 | Output enable pulling the alert line low |
| sdaDriveLow | output | 1 | Output enable pulling the data line low |
| arbLost | output | 1 | Last response lost arbitration |
| respWon | output | 1 | A response has been won and not yet retired |

## Verification
The bench models a second responder on the wired data line. It checks one case where the other responder has a lower address and this block must drop out at the first bit that differs. It checks another where the other address is higher and this block must finish. A design that compared addresses the wrong way round, or kept driving after a loss, would corrupt the line, and the per-bit drive checks would show it. Status reads are issued at three points: before any win, while the fault persists, and after it has cleared. A design that dropped the alert on a read alone, or on the fault clearing alone, would release the line too early. Polls while not alerting, writes and wrong addresses check that a non-alerting device stays off the bus, and an abort mid-byte checks that the line is released.

// File: rtl/alert_resp_pkg.sv
package alert_resp_pkg;
  localparam logic [6:0] DEFAULT_ALERT_ADDR = 7'b0001100;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture device address, reset bit counter
    logic shift;    // advance to next address bit
    logic drive;    // present current bit on the data line
    logic release_; // stop pulling the data line
  } strobes_t;
endpackage

// File: rtl/alert_resp_datapath.sv
module alert_resp_datapath
  import alert_resp_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [ADDR_W-1:0] devAddr,
  output logic              curBit,
  output logic              lastBit,
  output logic              sdaDriveLow
);
  localparam int CW = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

  logic [ADDR_W-1:0] shiftReg;
  logic [CW-1:0]     bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      bitCnt      <= '0;
      sdaDriveLow <= 1'b0;
    end else begin
      if (strobes.load) begin
        shiftReg <= devAddr;
        bitCnt   <= '0;
      end else if (strobes.shift) begin
        shiftReg <= {shiftReg[ADDR_W-2:0], 1'b0};
        bitCnt   <= bitCnt + 1'b1;
      end
      if (strobes.release_)
        sdaDriveLow <= 1'b0;
      else if (strobes.drive)
        sdaDriveLow <= ~shiftReg[ADDR_W-1];
    end
  end

  assign curBit  = shiftReg[ADDR_W-1];
  assign lastBit = (bitCnt == CW'(ADDR_W - 1));
endmodule

// File: rtl/alert_resp_ctrl.sv
module alert_resp_ctrl
  import alert_resp_pkg::*;
#(
  parameter int              NSTAT      = 8,
  parameter int              ADDR_W     = 7,
  parameter logic [ADDR_W-1:0] ALERT_ADDR = ADDR_W'(DEFAULT_ALERT_ADDR)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSTAT-1:0]  statusBits,
  input  logic [NSTAT-1:0]  statusMask,
  input  logic              statusRead,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addrByte,
  input  logic              addrRead,
  input  logic              busStop,
  input  logic              bitSlot,
  input  logic              bitSample,
  input  logic              sdaIn,
  input  logic              curBit,
  input  logic              lastBit,
  output strobes_t          strobes,
  output logic              alertPending,
  output logic              arbLost,
  output logic              respWon
);
  typedef enum logic {ST_IDLE, ST_SEND} state_t;

  state_t state;
  logic   faultNow, readSeen, pollHit, loseEv, winEv, releaseAlert;

  assign faultNow     = |(statusBits & statusMask);
  assign pollHit      = (state == ST_IDLE) && addrValid && addrRead &&
                        (addrByte == ALERT_ADDR) && alertPending;
  assign loseEv       = (state == ST_SEND) && !busStop && bitSample && curBit && !sdaIn;
  assign winEv        = (state == ST_SEND) && !busStop && bitSample && !loseEv && lastBit;
  assign releaseAlert = alertPending && respWon && (readSeen || statusRead) && !faultNow;

  always_comb begin
    strobes = '0;
    case (state)
      ST_IDLE: begin
        strobes.load     = pollHit;
        strobes.release_ = bitSlot || busStop;
      end
      ST_SEND: begin
        if (busStop || loseEv) strobes.release_ = 1'b1;
        else begin
          strobes.drive = bitSlot;
          strobes.shift = bitSample && !lastBit;
        end
      end
      default: strobes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      alertPending <= 1'b0;
      respWon      <= 1'b0;
      readSeen     <= 1'b0;
      arbLost      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (pollHit) state <= ST_SEND;
        ST_SEND: if (busStop || loseEv || winEv) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase

      if (releaseAlert) begin
        alertPending <= 1'b0;
        respWon      <= 1'b0;
        readSeen     <= 1'b0;
      end else begin
        if (faultNow) alertPending <= 1'b1;
        if (winEv) respWon <= 1'b1;
        if (statusRead && respWon) readSeen <= 1'b1;
      end

      if (pollHit) arbLost <= 1'b0;
      else if (loseEv) arbLost <= 1'b1;
    end
  end
endmodule

// File: rtl/alert_resp_top.sv
module alert_resp_top
  import alert_resp_pkg::*;
#(
  parameter int              NSTAT      = 8,
  parameter int              ADDR_W     = 7,
  parameter logic [ADDR_W-1:0] ALERT_ADDR = ADDR_W'(DEFAULT_ALERT_ADDR)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic [NSTAT-1:0]  statusBits,
  input  logic [NSTAT-1:0]  statusMask,
  input  logic              statusRead,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addrByte,
  input  logic              addrRead,
  input  logic              busStop,
  input  logic              bitSlot,
  input  logic              bitSample,
  input  logic              sdaIn,
  output logic              alertDriveLow,
  output logic              sdaDriveLow,
  output logic              arbLost,
  output logic              respWon
);
  strobes_t strobes;
  logic     curBit, lastBit;

  alert_resp_ctrl #(.NSTAT(NSTAT), .ADDR_W(ADDR_W), .ALERT_ADDR(ALERT_ADDR)) u_ctrl (
    .clk, .rstN, .statusBits, .statusMask, .statusRead, .addrValid, .addrByte,
    .addrRead, .busStop, .bitSlot, .bitSample, .sdaIn, .curBit, .lastBit,
    .strobes, .alertPending(alertDriveLow), .arbLost, .respWon
  );

  alert_resp_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk, .rstN, .strobes, .devAddr, .curBit, .lastBit, .sdaDriveLow
  );
endmodule

// File: rtl/alert_resp_chk.sv
module alert_resp_chk #(
  parameter int              NSTAT      = 8,
  parameter int              ADDR_W     = 7,
  parameter logic [ADDR_W-1:0] ALERT_ADDR = 7'b0001100
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] devAddr,
  input logic [NSTAT-1:0]  statusBits,
  input logic [NSTAT-1:0]  statusMask,
  input logic              alertDriveLow,
  input logic              sdaDriveLow,
  input logic              arbLost,
  input logic              respWon
);
  logic faultSeen;
  assign faultSeen = |(statusBits & statusMask);

  // R1: an enabled fault raises the alert on the next clock
  p_alert_raise_r1: assert property (@(posedge clk) disable iff (!rstN)
    faultSeen && !alertDriveLow |=> alertDriveLow);

  // R6: the data line is only pulled while alerting
  p_drive_needs_alert_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> $past(alertDriveLow));

  // R4: losing stops the drive and the loser keeps alerting
  p_loser_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbLost) |-> !sdaDriveLow && alertDriveLow);

  // R7: release only after a win and with the fault gone
  p_release_cond_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alertDriveLow) |-> $past(respWon) && !$past(faultSeen));

  // R9: own address differs from the alert response address
  p_addr_distinct_r9: assert property (@(posedge clk) disable iff (!rstN)
    devAddr != ALERT_ADDR);
endmodule

bind alert_resp_top alert_resp_chk #(.NSTAT(NSTAT), .ADDR_W(ADDR_W), .ALERT_ADDR(ALERT_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .devAddr(devAddr), .statusBits(statusBits),
  .statusMask(statusMask), .alertDriveLow(alertDriveLow), .sdaDriveLow(sdaDriveLow),
  .arbLost(arbLost), .respWon(respWon)
);

// File: tb/test_alert_resp_top.sv
module test_alert_resp_top;
  localparam logic [6:0] ARA = 7'b0001100;
  localparam logic [6:0] DEV = 7'h2C;

  logic clk = 1'b0, rstN = 1'b0;
  logic [6:0] devAddr = DEV;
  logic [7:0] statusBits = '0, statusMask = '0;
  logic statusRead = 0, addrValid = 0, addrRead = 0, busStop = 0;
  logic bitSlot = 0, bitSample = 0, sdaIn = 1;
  logic [6:0] addrByte = '0;
  logic alertDriveLow, sdaDriveLow, arbLost, respWon;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alert_resp_top i_alert_resp_top (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic pulseRead(); statusRead = 1; step(); statusRead = 0; endtask

  task automatic poll(input logic [6:0] a, input logic rd);
    addrByte = a; addrRead = rd; addrValid = 1; step(); addrValid = 0;
  endtask

  // response with an optional competing responder; checks every bit
  task automatic respond(input string req, input logic compOn, input logic [6:0] comp,
                         input logic alerting);
    logic lostE = 0, compLost = !compOn, line, ourDrive, cd;
    for (int i = 6; i >= 0; i--) begin
      bitSlot = 1; step(); bitSlot = 0;
      ourDrive = alerting && !lostE && !DEV[i];
      chk(req, sdaDriveLow, ourDrive);
      cd = !compLost && !comp[i];
      line = !(ourDrive || cd);
      if (alerting && !lostE && DEV[i] && !line) lostE = 1;
      if (!compLost && comp[i] && !line) compLost = 1;
      sdaIn = line; bitSample = 1; step(); bitSample = 0; sdaIn = 1;
    end
    if (alerting) begin
      chk({req, " lost flag"}, arbLost, lostE);
      chk({req, " won flag"}, respWon, !lostE);
    end
    bitSlot = 1; step(); bitSlot = 0;
    chk({req, " line released"}, sdaDriveLow, 1'b0);
  endtask

  task automatic tReset();
    chk("R1 reset alert", alertDriveLow, 0);
    chk("R3 reset sda", sdaDriveLow, 0);
    chk("R4 reset lost", arbLost, 0);
    chk("R5 reset won", respWon, 0);
  endtask

  task automatic tMasked();
    statusBits = 8'h10; statusMask = 8'h01; step(); step();
    chk("R1 masked bit", alertDriveLow, 0);
  endtask

  task automatic tIdlePoll();
    poll(ARA, 1); respond("R6 idle poll", 0, 7'h7F, 0);
    chk("R6 alert still off", alertDriveLow, 0);
  endtask

  task automatic tRaise();
    statusBits = 8'h11; step();
    chk("R1 enabled bit", alertDriveLow, 1);
  endtask

  task automatic tWrongAddr();
    poll(ARA, 0); respond("R2 write to ARA", 0, 7'h7F, 0);
    poll(DEV, 1); respond("R2 other address", 0, 7'h7F, 0);
    chk("R2 no win", respWon, 0);
  endtask

  task automatic tEarlyRead();
    pulseRead(); statusBits = 8'h00; step(); step();
    chk("R7 read before win", alertDriveLow, 1);
  endtask

  task automatic tLose();
    poll(ARA, 1); respond("R4 lower competitor", 1, 7'h2A, 1);
    chk("R4 loser keeps alert", alertDriveLow, 1);
  endtask

  task automatic tAbort();
    poll(ARA, 1);
    bitSlot = 1; step(); bitSlot = 0;
    chk("R8 first bit driven", sdaDriveLow, 1);
    sdaIn = 0; bitSample = 1; step(); bitSample = 0; sdaIn = 1;
    busStop = 1; step(); busStop = 0;
    chk("R8 abort releases", sdaDriveLow, 0);
    bitSlot = 1; step(); bitSlot = 0;
    chk("R8 stays released", sdaDriveLow, 0);
    chk("R8 no win", respWon, 0);
  endtask

  task automatic tWinHeldFault();
    poll(ARA, 1); respond("R3 R5 higher competitor", 1, 7'h4D, 1);
    step();
    chk("R7 no read yet", alertDriveLow, 1);
    statusBits = 8'h01; pulseRead(); step();
    chk("R7 fault persists", alertDriveLow, 1);
    statusBits = 8'h00; step();
    chk("R7 release on clear", alertDriveLow, 0);
    chk("R7 won retired", respWon, 0);
  endtask

  task automatic tWinAlone();
    statusBits = 8'h01; step(); statusBits = 8'h00; step();
    chk("R1 re-raise", alertDriveLow, 1);
    poll(ARA, 1); respond("R3 R5 sole responder", 0, 7'h7F, 1);
    pulseRead();
    chk("R7 read then release", alertDriveLow, 0);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1; step();
    tReset(); tMasked(); tIdlePoll(); tRaise(); tWrongAddr(); tEarlyRead();
    tLose(); tAbort(); tWinHeldFault(); tWinAlone();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule